// File: doc/BRIEF.md
# Time-of-Day Alarm Match Unit

This block watches the seconds, minutes and hours fields produced by a separate time-keeping counter. In the cycle in which that counter signals that an update has finished, the block compares all three fields against three alarm bytes. When every field agrees, it latches an alarm flag. An interrupt request follows the flag while the alarm-interrupt enable is high. The block does not count time itself.

An alarm byte whose two top bits are both 1 (0xC0 through 0xFF) is a wildcard that accepts any value of its field. This lets software ask for a hit every second, every minute or every hour. Hours are compared as a full byte, so in 12-hour mode the PM bit (bit 7) takes part in the match. The flag is read through a read strobe: the flag shows its value during the strobe cycle and is cleared after it.

Top module: `tod_alarm_match`

## Requirements
- R1: An alarm byte with bits 7 and 6 both 1 matches every value of its field. A byte with only bit 7 set (for example 0xBF) is not a wildcard.
- R2: A non-wildcard alarm byte matches only an identical 8-bit field value. A hit needs all three fields (seconds, minutes, hours) to match.
- R3: The hour compare covers bit 7 (PM in 12-hour mode). Alarm 0x82 hits at hour 0x82 but not at 0x02, and alarm 0x02 does not hit at 0x82.
- R4: The compare is evaluated only in a cycle with `upd_done` high. Matching values with no strobe never set the flag.
- R5: A hit sets `alarm_flag` on the next clock edge, and the flag holds until it is read.
- R6: A cycle with `stat_rd` high presents the current flag, and the flag is 0 from the next cycle on. A second read straight after returns 0.
- R7: `irq` is high exactly when `alarm_flag` and `alarm_ie` are both 1. With `alarm_ie` low the flag is still set by a hit, but `irq` stays 0.
- R8: If a hit and a read fall in the same cycle, the flag is 1 afterwards. The new event is not lost.
- R9: After reset, `alarm_flag` and `irq` are 0.
- R10: With the minutes and hours alarms set to wildcards and the seconds alarm set to a fixed BCD value, the block fires exactly once per 60 consecutive one-second updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_done | input | 1 | Time update finished; compare this cycle |
| cur_sec | input | 8 | Current seconds field |
| cur_min | input | 8 | Current minutes field |
| cur_hr | input | 8 | Current hours field (bit 7 = PM in 12-hour mode) |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| alarm_ie | input | 1 | Alarm interrupt enable |
| stat_rd | input | 1 | Status read strobe (clear on read) |
| alarm_flag | output | 1 | Latched alarm flag |
| irq | output | 1 | Interrupt request |

## Verification
A hit from an update strobe and a clear from a status read can land in the same clock cycle. The two then compete for the one flag bit. The bench provokes this by first leaving the flag set, then raising `upd_done` with matching fields and `stat_rd` together. It judges the result by checking that the read cycle still shows the old flag and that the flag reads 1 on the following cycle, so the new alarm survives the clear.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
    localparam int unsigned FIELD_W    = 8;
    localparam int unsigned NUM_FIELDS = 3;

    typedef struct packed {
        logic flag;
    } alm_state_t;
endpackage

// File: rtl/tod_alarm_field_cmp.sv
module tod_alarm_field_cmp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cur_val,
    input  logic [W-1:0] alm_val,
    output logic         hit
);
    logic wild;

    always_comb begin
        wild = &alm_val[W-1:W-2];
        hit  = wild || (cur_val == alm_val);
    end
endmodule

// File: rtl/tod_alarm_status_reg.sv
module tod_alarm_status_reg
    import tod_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    alm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) st_d.flag = 1'b0;
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
#(
    parameter int unsigned FW = FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_done,
    input  logic [FW-1:0] cur_sec,
    input  logic [FW-1:0] cur_min,
    input  logic [FW-1:0] cur_hr,
    input  logic [FW-1:0] alm_sec,
    input  logic [FW-1:0] alm_min,
    input  logic [FW-1:0] alm_hr,
    input  logic          alarm_ie,
    input  logic          stat_rd,
    output logic          alarm_flag,
    output logic          irq
);
    localparam int unsigned NF = NUM_FIELDS;

    logic [FW-1:0] cur_arr [NF];
    logic [FW-1:0] alm_arr [NF];
    logic [NF-1:0] fld_hit;
    logic          evt_d;

    always_comb begin
        cur_arr[0] = cur_sec;
        cur_arr[1] = cur_min;
        cur_arr[2] = cur_hr;
        alm_arr[0] = alm_sec;
        alm_arr[1] = alm_min;
        alm_arr[2] = alm_hr;
    end

    for (genvar g = 0; g < NF; g++) begin : g_fld
        tod_alarm_field_cmp #(.W(FW)) u_cmp (
            .cur_val (cur_arr[g]),
            .alm_val (alm_arr[g]),
            .hit     (fld_hit[g])
        );
    end

    always_comb evt_d = upd_done && (&fld_hit);

    tod_alarm_status_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_d),
        .clr_i  (stat_rd),
        .flag_o (alarm_flag)
    );

    always_comb irq = alarm_flag && alarm_ie;
endmodule

// File: rtl/tod_alarm_match_chk.sv
module tod_alarm_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_done,
    input logic [7:0] cur_sec,
    input logic [7:0] alm_sec,
    input logic       alarm_ie,
    input logic       stat_rd,
    input logic       alarm_flag,
    input logic       irq
);
    a_r4_set_needs_update: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(upd_done));

    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !stat_rd) |=> alarm_flag);

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !upd_done) |=> !alarm_flag);

    a_r2_sec_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_done && !alarm_flag && (alm_sec[7:6] != 2'b11) && (cur_sec != alm_sec))
        |=> !alarm_flag);

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_ie || !alarm_flag) |-> !irq);
endmodule

bind tod_alarm_match tod_alarm_match_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_done   (upd_done),
    .cur_sec    (cur_sec),
    .alm_sec    (alm_sec),
    .alarm_ie   (alarm_ie),
    .stat_rd    (stat_rd),
    .alarm_flag (alarm_flag),
    .irq        (irq)
);

// File: tb/tod_alarm_match_tb_top.sv
module tod_alarm_match_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_done = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hr = '0;
    logic [7:0] alm_sec = '0, alm_min = '0, alm_hr = '0;
    logic alarm_ie = 1'b0;
    logic stat_rd = 1'b0;
    logic alarm_flag, irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tod_alarm_match dut_i (
        .clk(clk), .rst_n(rst_n), .upd_done(upd_done),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .alarm_ie(alarm_ie), .stat_rd(stat_rd),
        .alarm_flag(alarm_flag), .irq(irq)
    );

    // {cur_sec, cur_min, cur_hr, alm_sec, alm_min, alm_hr, expected flag}
    localparam logic [55:0] VEC [8] = '{
        {8'h58, 8'h04, 8'h02, 8'h58, 8'h04, 8'h02, 8'h01}, // R2 exact
        {8'h57, 8'h04, 8'h02, 8'h58, 8'h04, 8'h02, 8'h00}, // R2 sec differs
        {8'h10, 8'h20, 8'h15, 8'h10, 8'h20, 8'hC0, 8'h01}, // R1 wild hour
        {8'h33, 8'h44, 8'h91, 8'hFF, 8'hC7, 8'hE2, 8'h01}, // R1 all wild
        {8'h00, 8'h00, 8'h02, 8'hC0, 8'hC0, 8'h82, 8'h00}, // R3 2AM vs 2PM alarm
        {8'h00, 8'h00, 8'h82, 8'hC0, 8'hC0, 8'h82, 8'h01}, // R3 2PM hit
        {8'h00, 8'h00, 8'h82, 8'hC0, 8'hC0, 8'h02, 8'h00}, // R3 2AM alarm at 2PM
        {8'h00, 8'h3F, 8'h01, 8'h00, 8'hBF, 8'h01, 8'h00}  // R1 0xBF not wild
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_read();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic pulse_upd();
        @(negedge clk) upd_done = 1'b1;
        @(negedge clk) upd_done = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int fires;
        repeat (3) @(negedge clk);
        chk("R9 flag", alarm_flag, 1'b0);
        chk("R9 irq", irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // table
        foreach (VEC[i]) begin
            logic [55:0] v;
            v = VEC[i];
            @(negedge clk);
            {cur_sec, cur_min, cur_hr, alm_sec, alm_min, alm_hr} = v[55:8];
            pulse_upd();
            chk($sformatf("R1/R2/R3 vec%0d", i), alarm_flag, v[0]);
            do_read();
            chk("R6 cleared", alarm_flag, 1'b0);
        end

        // R4: matching values, no strobe
        @(negedge clk);
        {cur_sec, cur_min, cur_hr} = {8'h11, 8'h22, 8'h03};
        {alm_sec, alm_min, alm_hr} = {8'h11, 8'h22, 8'h03};
        repeat (5) @(negedge clk);
        chk("R4 no strobe", alarm_flag, 1'b0);

        // R5 hold, R7 irq
        alarm_ie = 1'b1;
        pulse_upd();
        chk("R5 set", alarm_flag, 1'b1);
        chk("R7 irq on", irq, 1'b1);
        {cur_sec} = 8'h12;
        repeat (4) @(negedge clk);
        chk("R5 hold", alarm_flag, 1'b1);
        alarm_ie = 1'b0;
        #0.5;
        chk("R7 irq off", irq, 1'b0);
        chk("R7 flag kept", alarm_flag, 1'b1);

        // R6 read returns then clears; second read zero
        @(negedge clk) stat_rd = 1'b1;
        #0.5 chk("R6 read shows flag", alarm_flag, 1'b1);
        @(negedge clk) chk("R6 after read", alarm_flag, 1'b0);
        @(negedge clk) stat_rd = 1'b0;
        chk("R6 second read", alarm_flag, 1'b0);

        // R7: ie low, hit still sets flag
        cur_sec = 8'h11;
        pulse_upd();
        chk("R7 flag with ie low", alarm_flag, 1'b1);
        chk("R7 irq with ie low", irq, 1'b0);

        // R8: hit and read in same cycle
        @(negedge clk);
        upd_done = 1'b1;
        stat_rd = 1'b1;
        #0.5 chk("R8 read shows old", alarm_flag, 1'b1);
        @(negedge clk);
        upd_done = 1'b0;
        stat_rd = 1'b0;
        chk("R8 set wins", alarm_flag, 1'b1);
        do_read();

        // R10: seconds alarm 0x30, others wild, 120 one-second updates
        {alm_sec, alm_min, alm_hr} = {8'h30, 8'hC0, 8'hFF};
        fires = 0;
        for (int k = 0; k < 120; k++) begin
            int s;
            s = k % 60;
            cur_sec = {4'(s / 10), 4'(s % 10)};
            cur_min = 8'(k / 60);
            pulse_upd();
            if (alarm_flag) fires++;
            do_read();
        end
        n_run++;
        if (fires != 2) begin
            n_fail++;
            $display("FAIL R10: actual %0d expected 2", fires);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule